// File: doc/BRIEF.md
# Keccak Vector Execution Unit

This unit runs four 128-bit vector operations that shorten the inner loop of a Keccak (SHA-3) round. They are a three-input XOR, an XOR with a bit-cleared operand, a one-bit left rotate folded into an XOR, and an XOR followed by a right rotate by an immediate. Each cycle the unit accepts one 32-bit instruction word with a valid strobe. It compares the word against four fixed opcode patterns and extracts the register fields. It reads up to three sources from a private file of 32 registers, each 128 bits wide, and writes the result back one clock later.

A word that matches none of the patterns raises a one-cycle `illegal` flag and changes no register. A load port presets registers and a combinational peek port reads back committed state. The peek port is how a bench or the surrounding logic sees results. Results still waiting to commit are forwarded to the sources of the next instruction, so dependent instructions can issue back to back.

Top module: `keccak_vec_unit`

## Requirements
- R1: When `rst` is high at a rising edge, all 32 registers become zero, including any register that was loaded before that reset.
- R2: Decoding uses these fields: destination in bits 4:0, source n in bits 9:5, source m in bits 20:16, source a in bits 14:10, and rotate amount in bits 15:10. Word 0xCE260E33 is the bit-clear XOR with d=19, n=17, m=6, a=3. Word 0xCE921118 is the XOR-rotate with d=24, n=8, m=18 and a rotate of 4.
- R3: Under mask 0xFFE08000, a word equal to 0xCE000000 writes n ^ m ^ a to the destination.
- R4: Under mask 0xFFE08000, a word equal to 0xCE200000 writes n ^ (m & ~a) to the destination.
- R5: Under mask 0xFFE0FC00, a word equal to 0xCE608C00 treats each 64-bit lane separately and writes n ^ (m rotated left by 1) to it. Bit 63 of m wraps to bit 0 within the same lane.
- R6: Under mask 0xFFE00000, a word equal to 0xCE800000 treats each 64-bit lane separately and writes (n ^ m) rotated right by the 6-bit amount. A rotate of 0 passes the XOR through unchanged, and 63 is a legal amount.
- R7: A valid word that matches none of the four patterns sets `illegal` high in the cycle after the edge that accepted it, and no register changes.
- R8: The result commits on the second rising edge after the word is presented, which is one clock after the accepting edge. Sources are the values from before that write, so a destination equal to any source gives the correct result.
- R9: An instruction issued in the cycle right after another one sees that earlier result in its sources. This also holds when a source is the pending destination.
- R10: With `loadEn` high, `loadData` is written to `loadIdx` at the rising edge. If a pending result targets the same register at that edge, the load wins.
- R11: `peekData` shows the committed content of register `peekIdx` without delay.
- R12: While `insnValid` is low, the word is ignored: no register changes and `illegal` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| insnValid | input | 1 | Instruction word is present this cycle |
| insnWord | input | 32 | Instruction word |
| illegal | output | 1 | Previous accepted word matched no pattern |
| loadEn | input | 1 | Register preset strobe |
| loadIdx | input | 5 | Register written by the preset |
| loadData | input | 128 | Preset value |
| peekIdx | input | 5 | Register shown on peekData |
| peekData | output | 128 | Committed content of register peekIdx |

## Verification
The bench builds the unit with its defaults: 128-bit vectors made of two 64-bit lanes and 32 registers. Operands are chosen so that lane-boundary bits differ. A rotation that leaked across lanes, or a one-bit left rotate that lost its wrap, would then show in the upper word. Full 5-bit register fields are used with indices up to 31, which covers the two encoded examples and the high register numbers. Rotate amounts 0, 1, 4, 36 and 63 probe both ends of the immediate range.

// File: rtl/kvu_pkg.sv
package kvu_pkg;

  localparam int INSN_W   = 32;
  localparam int REG_AW   = 5;
  localparam int NUM_REGS = 1 << REG_AW;
  localparam int ROT_FW   = 6;
  localparam int NUM_OPS  = 4;

  typedef enum logic [1:0] {
    OP_XOR3 = 2'd0,
    OP_BICX = 2'd1,
    OP_ROLX = 2'd2,
    OP_XROR = 2'd3
  } op_e;

  // Fixed-bit masks and match values, indexed by op_e
  localparam logic [NUM_OPS-1:0][INSN_W-1:0] OP_MASK = {
    32'hFFE0_0000,   // XROR: register and rotate fields free
    32'hFFE0_FC00,   // ROLX: bits 15:10 fixed
    32'hFFE0_8000,   // BICX: bit 15 fixed
    32'hFFE0_8000    // XOR3
  };
  localparam logic [NUM_OPS-1:0][INSN_W-1:0] OP_MATCH = {
    32'hCE80_0000,
    32'hCE60_8C00,
    32'hCE20_0000,
    32'hCE00_0000
  };

  // Strobes and fields handed from decode to the datapath
  typedef struct packed {
    logic              issue;
    logic              reject;
    op_e               op;
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] srcN;
    logic [REG_AW-1:0] srcM;
    logic [REG_AW-1:0] srcA;
    logic [ROT_FW-1:0] rot;
  } ctl_t;

endpackage

// File: rtl/kvu_decode.sv
module kvu_decode
  import kvu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              insnValid,
  input  logic [INSN_W-1:0] insnWord,
  output ctl_t              ctl,
  output logic              illegal
);

  logic [NUM_OPS-1:0] hit;
  op_e                opSel;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_match
    assign hit[i] = (insnWord & OP_MASK[i]) == OP_MATCH[i];
  end

  always_comb begin
    opSel = OP_XOR3;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (hit[i]) opSel = op_e'(i);
    end
  end

  always_comb begin
    ctl.issue  = insnValid && (|hit);
    ctl.reject = insnValid && !(|hit);
    ctl.op     = opSel;
    ctl.dst    = insnWord[4:0];
    ctl.srcN   = insnWord[9:5];
    ctl.srcM   = insnWord[20:16];
    ctl.srcA   = insnWord[14:10];
    ctl.rot    = insnWord[15:10];
  end

  always_ff @(posedge clk) begin
    if (rst) illegal <= 1'b0;
    else     illegal <= ctl.reject;
  end

  // R7
  illegal_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(insnValid));

endmodule

// File: rtl/kvu_datapath.sv
module kvu_datapath
  import kvu_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic              loadEn,
  input  logic [REG_AW-1:0] loadIdx,
  input  logic [VEC_W-1:0]  loadData,
  input  logic [REG_AW-1:0] peekIdx,
  output logic [VEC_W-1:0]  peekData,
  output logic              wbValid
);

  localparam int NLANE = VEC_W / LANE_W;
  localparam int ROT_W = $clog2(LANE_W);
  localparam int NSRC  = 3;

  logic [VEC_W-1:0]  regs [NUM_REGS];
  logic [REG_AW-1:0] wbIdx;
  logic [VEC_W-1:0]  wbData;
  logic [VEC_W-1:0]  result;

  logic [REG_AW-1:0] srcIdx [NSRC];
  logic [VEC_W-1:0]  opnd   [NSRC];

  assign srcIdx[0] = ctl.srcN;
  assign srcIdx[1] = ctl.srcM;
  assign srcIdx[2] = ctl.srcA;

  // Operand fetch: same-edge load first, then pending result, then file
  for (genvar s = 0; s < NSRC; s++) begin : g_fetch
    always_comb begin
      if (loadEn && loadIdx == srcIdx[s])      opnd[s] = loadData;
      else if (wbValid && wbIdx == srcIdx[s])  opnd[s] = wbData;
      else                                     opnd[s] = regs[srcIdx[s]];
    end
  end

  // Per-lane compute
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0]   nL, mL, aL, xL, outL;
    logic [2*LANE_W-1:0] dblM, dblX;

    assign nL   = opnd[0][g*LANE_W +: LANE_W];
    assign mL   = opnd[1][g*LANE_W +: LANE_W];
    assign aL   = opnd[2][g*LANE_W +: LANE_W];
    assign xL   = nL ^ mL;
    assign dblM = {mL, mL} >> (LANE_W - 1);
    assign dblX = {xL, xL} >> ctl.rot[ROT_W-1:0];

    always_comb begin
      unique case (ctl.op)
        OP_XOR3: outL = nL ^ mL ^ aL;
        OP_BICX: outL = nL ^ (mL & ~aL);
        OP_ROLX: outL = nL ^ dblM[LANE_W-1:0];
        OP_XROR: outL = dblX[LANE_W-1:0];
        default: outL = '0;
      endcase
    end

    assign result[g*LANE_W +: LANE_W] = outL;
  end

  // Writeback stage
  always_ff @(posedge clk) begin
    if (rst) begin
      wbValid <= 1'b0;
      wbIdx   <= '0;
      wbData  <= '0;
    end else begin
      wbValid <= ctl.issue;
      wbIdx   <= ctl.dst;
      wbData  <= result;
    end
  end

  // Register file; the load is written last so it wins a collision
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) regs[r] <= '0;
    end else begin
      if (wbValid) regs[wbIdx]   <= wbData;
      if (loadEn)  regs[loadIdx] <= loadData;
    end
  end

  assign peekData = regs[peekIdx];

  // R8
  commit_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wbValid && !(loadEn && loadIdx == wbIdx)) |=> regs[$past(wbIdx)] == $past(wbData));

  // R10
  load_lands_chk: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> regs[$past(loadIdx)] == $past(loadData));

endmodule

// File: rtl/keccak_vec_unit.sv
module keccak_vec_unit
  import kvu_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insnValid,
  input  logic [INSN_W-1:0] insnWord,
  output logic              illegal,
  input  logic              loadEn,
  input  logic [REG_AW-1:0] loadIdx,
  input  logic [VEC_W-1:0]  loadData,
  input  logic [REG_AW-1:0] peekIdx,
  output logic [VEC_W-1:0]  peekData
);

  ctl_t ctl;
  logic wbValid;

  kvu_decode u_decode (
    .clk       (clk),
    .rst       (rst),
    .insnValid (insnValid),
    .insnWord  (insnWord),
    .ctl       (ctl),
    .illegal   (illegal)
  );

  kvu_datapath #(
    .VEC_W  (VEC_W),
    .LANE_W (LANE_W)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .loadEn   (loadEn),
    .loadIdx  (loadIdx),
    .loadData (loadData),
    .peekIdx  (peekIdx),
    .peekData (peekData),
    .wbValid  (wbValid)
  );

  // R7
  illegal_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wbValid);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !insnValid |=> (!wbValid && !illegal));

endmodule

// File: tb/keccak_vec_unit_tb.sv
module keccak_vec_unit_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         insnValid = 1'b0;
  logic [31:0]  insnWord = '0;
  logic         illegal;
  logic         loadEn = 1'b0;
  logic [4:0]   loadIdx = '0;
  logic [127:0] loadData = '0;
  logic [4:0]   peekIdx = '0;
  logic [127:0] peekData;

  always #5 clk = ~clk;

  keccak_vec_unit u_dut (
    .clk(clk), .rst(rst), .insnValid(insnValid), .insnWord(insnWord),
    .illegal(illegal), .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData),
    .peekIdx(peekIdx), .peekData(peekData)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  logic [127:0] model [32];

  typedef struct { int due; logic [4:0] idx; logic [127:0] data; string req; } regItem_t;
  typedef struct { int due; logic exp; string req; } flagItem_t;
  regItem_t  regQ[$];
  flagItem_t flagQ[$];

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rotr64(logic [63:0] x, int s);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = x[(i + s) % 64];
    return r;
  endfunction

  // kind: 0 xor3, 1 bit-clear xor, 2 rotate-left-1 xor, 3 xor-rotate, 4 illegal
  function automatic logic [127:0] calc(int kind, logic [127:0] n, logic [127:0] m,
                                        logic [127:0] a, int rot);
    logic [127:0] r;
    r = '0;
    for (int l = 0; l < 2; l++) begin
      case (kind)
        0: r[l*64 +: 64] = n[l*64 +: 64] ^ m[l*64 +: 64] ^ a[l*64 +: 64];
        1: r[l*64 +: 64] = n[l*64 +: 64] ^ (m[l*64 +: 64] & ~a[l*64 +: 64]);
        2: r[l*64 +: 64] = n[l*64 +: 64] ^ rotr64(m[l*64 +: 64], 63);
        3: r[l*64 +: 64] = rotr64(n[l*64 +: 64] ^ m[l*64 +: 64], rot);
        default: r[l*64 +: 64] = '0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] enc(logic [31:0] base, int d, int n, int m, int f);
    return base | (32'(m) << 16) | (32'(f) << 10) | (32'(n) << 5) | 32'(d);
  endfunction

  task automatic issue(logic [31:0] w, int kind, int d, int n, int m, int a, int rot,
                       bit valid, bit track, string req);
    logic [127:0] res;
    flagItem_t fi;
    regItem_t  ri;
    res = calc(kind, model[n], model[m], model[a], rot);
    insnValid = valid;
    insnWord  = w;
    fi.due = cyc + 1; fi.exp = valid && (kind == 4); fi.req = req;
    flagQ.push_back(fi);
    if (valid && kind != 4) begin
      if (track) begin
        ri.due = cyc + 2; ri.idx = 5'(d); ri.data = res; ri.req = req;
        regQ.push_back(ri);
      end
      model[d] = res;
    end
    @(posedge clk);
    @(negedge clk);
    insnValid = 1'b0;
  endtask

  task automatic opX3(int d, int n, int m, int a, string req);
    issue(enc(32'hCE000000, d, n, m, a), 0, d, n, m, a, 0, 1, 1, req);
  endtask
  task automatic opBc(int d, int n, int m, int a, string req);
    issue(enc(32'hCE200000, d, n, m, a), 1, d, n, m, a, 0, 1, 1, req);
  endtask
  task automatic opRl(int d, int n, int m, string req);
    issue(enc(32'hCE608C00, d, n, m, 0), 2, d, n, m, 0, 0, 1, 1, req);
  endtask
  task automatic opXr(int d, int n, int m, int rot, string req);
    issue(enc(32'hCE800000, d, n, m, rot), 3, d, n, m, 0, rot, 1, 1, req);
  endtask

  task automatic load(int idx, logic [127:0] data);
    loadEn = 1'b1; loadIdx = 5'(idx); loadData = data;
    model[idx] = data;
    @(posedge clk);
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic drain();
    while (regQ.size() > 0 || flagQ.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic dump(string req);
    for (int i = 0; i < 32; i++) begin
      peekIdx = 5'(i);
      #0.2;
      chk(req, peekData, model[i]);
    end
    @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    flagItem_t f;
    regItem_t  r;
    if (!rst) begin
      if (flagQ.size() > 0 && flagQ[0].due == cyc) begin
        f = flagQ.pop_front();
        chk({f.req, " illegal flag"}, {127'd0, illegal}, {127'd0, f.exp});
      end
      if (regQ.size() > 0 && regQ[0].due == cyc) begin
        r = regQ.pop_front();
        peekIdx = r.idx;
        #1;
        chk(r.req, peekData, r.data);
      end
    end
  end

  initial begin
    repeat (10000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R11: preset then peek
    load(1, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE);
    peekIdx = 5'd1; #1;
    chk("R11 peek after load", peekData, 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE);
    @(negedge clk);
    // R1: reset clears everything
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    dump("R1 reset");

    // R10: fill file through load port
    for (int i = 0; i < 32; i++) load(i, {$urandom, $urandom, $urandom, $urandom});
    load(10, 128'h8000_0000_0000_0001_7FFF_FFFF_FFFF_FFFF);
    load(21, 128'h0000_0000_0000_0001_8000_0000_0000_0000);
    dump("R10 load");

    // Main functions, issued back to back
    opX3(2, 3, 4, 5, "R3");
    opX3(31, 30, 29, 28, "R3");
    opBc(11, 12, 13, 14, "R4");
    opBc(0, 31, 21, 10, "R4");
    issue(32'hCE260E33, 1, 19, 17, 6, 3, 0, 1, 1, "R2 bcax vector");
    opRl(20, 10, 21, "R5");
    opRl(22, 23, 10, "R5");
    opXr(24, 25, 26, 0, "R6 rot0");
    opXr(27, 25, 26, 63, "R6 rot63");
    opXr(28, 10, 21, 1, "R6 rot1");
    opXr(29, 10, 23, 36, "R6 rot36");
    issue(32'hCE921118, 3, 24, 8, 18, 0, 4, 1, 1, "R2 xar vector");
    drain();

    // R8: destination equals source
    opX3(15, 15, 15, 15, "R8");
    opBc(16, 16, 16, 17, "R8");
    opRl(18, 18, 18, "R8");
    opXr(14, 14, 14, 9, "R8");
    drain();

    // R9: dependent chain
    opX3(5, 1, 2, 3, "R9");
    opBc(6, 5, 5, 4, "R9");
    opXr(7, 6, 5, 13, "R9");
    opRl(8, 7, 7, "R9");
    drain();

    // R7: non-matching words
    issue(32'h0000_0000, 4, 0, 0, 0, 0, 0, 1, 1, "R7");
    issue(32'hCE00_8000, 4, 0, 0, 0, 0, 0, 1, 1, "R7");
    issue(32'hCE60_8000, 4, 0, 0, 0, 0, 0, 1, 1, "R7");
    issue(32'hCEA0_0000, 4, 0, 0, 0, 0, 0, 1, 1, "R7");
    issue(32'hCE60_0000, 4, 0, 0, 0, 0, 0, 1, 1, "R7");
    drain();
    dump("R7 no change");

    // R12: valid low
    issue(enc(32'hCE000000, 9, 1, 2, 3), 0, 9, 1, 2, 3, 0, 0, 1, "R12");
    issue(32'h0000_0000, 4, 0, 0, 0, 0, 0, 0, 1, "R12");
    drain();
    dump("R12 ignored");

    // R10: load collides with pending result
    issue(enc(32'hCE800000, 30, 1, 2, 5), 3, 30, 1, 2, 0, 5, 1, 0, "R10");
    load(30, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
    drain();
    peekIdx = 5'd30; #1;
    chk("R10 load wins", peekData, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
    @(negedge clk);
    dump("R8 final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule